// File: doc/BRIEF.md
# Pipelined Byte-Writable Synchronous SRAM

This block is a synchronous static memory for on-chip use. Every access is set up by a single clock edge. That edge captures the address, the write strobes and the three chip-select inputs. Each word holds four byte lanes. Each lane carries an optional extra check bit, so a word is 32 or 36 bits wide. The depth is a parameter and stays small enough for flip-flops or an inferred RAM.

Writes finish at the edge that captures them. Read data moves through two register stages: the address register, then the output register. It appears one cycle after the address is captured. There is no tri-state pad. The data output comes with a drive flag that says when a device would drive the shared bus. Because selection takes two edges to reach that flag and deselection one, devices placed side by side in depth never drive at the same time.

The access port has no valid/ready handshake. Every selected, awake cycle is accepted, so back-pressure never arises. The output-enable and sleep inputs act on the drive flag without waiting for a clock edge.

Top module: `pipe_bw_sram`

## Requirements
- R1: While reset is held and after reset releases, `dout_en` stays low until a selected read has completed.
- R2: With `wr_all_n` low at a capture edge, every lane of the addressed word takes `din`, whatever `wr_lane_en_n` and `lane_wr_n` are.
- R3: With `wr_all_n` high, lane i is written only when `wr_lane_en_n` and `lane_wr_n[i]` are both low. Other lanes keep their contents. When no lane qualifies, the cycle is a read.
- R4: A read captured at edge k presents the word on `dout` with `dout_en` high after edge k+1, provided the device is selected and awake at edge k+1.
- R5: A read captured on the edge right after a write to the same address returns the newly written data.
- R6: An access is accepted only when `sel0_n` is low, `sel1` is high and `sel2_n` is low at the capture edge. Otherwise, a write leaves the array untouched.
- R7: A deselect captured at an edge drops `dout_en` right after that edge. A select arriving from the deselected state raises `dout_en` only after the second edge.
- R8: `oe_n` high forces `dout_en` low at once, with no clock edge needed. Returning `oe_n` low restores the registered drive state.
- R9: While `sleep` is high, `dout_en` is low at once, no write changes the array, and no read is started.
- R10: Lane i occupies bits [i*(8+P) +: 8+P] of `din` and `dout`, where P is the check-bit width (0 or 1). The check bit is the top bit of its lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| sleep | input | 1 | Power-down: blocks all access and drive |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| wr_all_n | input | 1 | Whole-word write strobe, active low |
| wr_lane_en_n | input | 1 | Lane-write qualifier, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| din | input | WORD_W | Write data |
| dout | output | WORD_W | Registered read data |
| dout_en | output | 1 | Data drive flag standing in for the pad enable |

## Verification
The bench builds the block with a 4-bit address and one check bit per lane. That gives 16 words of 36 bits. Every word can be preloaded and revisited, and the top bit of every lane can be written and compared. The default lane count and lane width are kept, so the bit positions of R10 are the ones a 36-bit system would use. A whole-word write can therefore carry a partial lane-strobe pattern, which shows that the strobes are ignored in that case.

// File: rtl/pbw_sram_pkg.sv
package pbw_sram_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  // all three selects in their active level
  function automatic logic chip_active(input logic s0_n, input logic s1, input logic s2_n);
    return !s0_n && s1 && !s2_n;
  endfunction

endpackage

// File: rtl/pbw_wr_decode.sv
module pbw_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             wr_all_n,
  input  logic             wr_lane_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] lane_req
);

  // whole-word strobe dominates; otherwise qualifier AND lane strobe
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_req[g] = !wr_all_n || (!wr_lane_en_n && !lane_wr_n[g]);
  end

endmodule

// File: rtl/pbw_access_ctrl.sv
module pbw_access_ctrl
  import pbw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_req,
  output logic [LANES-1:0]  wr_mask,
  output logic              rd_fire,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              drive
);

  logic              acc_ok;
  acc_kind_e         kind;
  logic              s1_rd;
  logic [ADDR_W-1:0] s1_addr;
  logic              drv_q;

  always_comb begin
    acc_ok = chip_active(sel0_n, sel1, sel2_n) && !sleep;
    if (!acc_ok)        kind = ACC_IDLE;
    else if (|lane_req) kind = ACC_WRITE;
    else                kind = ACC_READ;
  end

  // writes complete at the capture edge
  assign wr_mask = (kind == ACC_WRITE) ? lane_req : '0;

  // stage 1: address register; drive follows the pending read,
  // and any deselect or sleep at an edge clears it at that edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_rd   <= 1'b0;
      s1_addr <= '0;
      drv_q   <= 1'b0;
    end else begin
      s1_rd <= (kind == ACC_READ);
      if (kind == ACC_READ) s1_addr <= addr;
      drv_q <= acc_ok && s1_rd;
    end
  end

  assign rd_fire = s1_rd && acc_ok;
  assign rd_addr = s1_addr;
  assign drive   = drv_q;

  // R4: read then a selected cycle gives drive
  p_read_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_READ) ##1 acc_ok |=> drv_q);

  // R7: deselect at an edge cuts drive after it
  p_desel_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_active(sel0_n, sel1, sel2_n) |=> !drv_q);

  // R7: from idle, drive cannot rise after a single edge
  p_select_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!s1_rd && !drv_q) |=> !drv_q);

  // R9: sleep at an edge leaves nothing to drive
  p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!drv_q && !s1_rd));

endmodule

// File: rtl/pbw_store.sv
module pbw_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    rd_fire,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q_lane;

    always_ff @(posedge clk) begin
      if (wr_mask[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    // stage 2: output register
    always_ff @(posedge clk) begin
      if (rd_fire) q_lane <= mem[rd_addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = q_lane;

    // R3: an enabled lane holds the written slice afterwards
    p_lane_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask[g] |=> (mem[$past(wr_addr)] == $past(wr_data[g*LANE_W +: LANE_W])));
  end

endmodule

// File: rtl/pipe_bw_sram.sv
module pipe_bw_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int PAR_W  = 1,
  localparam int LANE_W = BYTE_W + PAR_W,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_all_n,
  input  logic              wr_lane_en_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);

  logic [LANES-1:0]  lane_req;
  logic [LANES-1:0]  wr_mask;
  logic              rd_fire;
  logic [ADDR_W-1:0] rd_addr;
  logic              drive;

  pbw_wr_decode #(.LANES(LANES)) u_dec (
    .wr_all_n     (wr_all_n),
    .wr_lane_en_n (wr_lane_en_n),
    .lane_wr_n    (lane_wr_n),
    .lane_req     (lane_req)
  );

  pbw_access_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .sel0_n   (sel0_n),
    .sel1     (sel1),
    .sel2_n   (sel2_n),
    .addr     (addr),
    .lane_req (lane_req),
    .wr_mask  (wr_mask),
    .rd_fire  (rd_fire),
    .rd_addr  (rd_addr),
    .drive    (drive)
  );

  pbw_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mask (wr_mask),
    .wr_addr (addr),
    .wr_data (din),
    .rd_fire (rd_fire),
    .rd_addr (rd_addr),
    .rd_data (dout)
  );

  // asynchronous gating of the pad stand-in
  assign dout_en = drive && !oe_n && !sleep;

  // R6: a deselected cycle never reaches the array
  p_desel_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0_n || !sel1 || sel2_n) |-> (wr_mask == '0));

endmodule

// File: tb/pipe_bw_sram_tb_top.sv
module pipe_bw_sram_tb_top;

  localparam int AW = 4;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int WW = NL * LW;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n, sleep, sel0_n, sel1, sel2_n, oe_n;
  logic [AW-1:0] addr;
  logic          wr_all_n, wr_lane_en_n;
  logic [NL-1:0] lane_wr_n;
  logic [WW-1:0] din, dout;
  logic          dout_en;

  logic [WW-1:0] model [NW];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pipe_bw_sram #(.ADDR_W(AW), .LANES(NL), .BYTE_W(8), .PAR_W(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .oe_n(oe_n), .addr(addr), .wr_all_n(wr_all_n),
    .wr_lane_en_n(wr_lane_en_n), .lane_wr_n(lane_wr_n), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  // vector: kind(2) addr(4) lane mask(4) data(36); kind 0 whole write, 1 lane write, 2 read
  localparam int VN = 14;
  localparam logic [45:0] VEC [VN] = '{
    {2'd1, 4'd3,  4'b0001, 36'h1_2345_6789},
    {2'd2, 4'd3,  4'b0000, 36'h0},
    {2'd1, 4'd3,  4'b1010, 36'hF_EDCB_A987},
    {2'd2, 4'd3,  4'b0000, 36'h0},
    {2'd0, 4'd7,  4'b0100, 36'hA_5A5A_5A5A},
    {2'd2, 4'd7,  4'b0000, 36'h0},
    {2'd1, 4'd7,  4'b1111, 36'h0_F0F0_F0F0},
    {2'd2, 4'd7,  4'b0000, 36'h0},
    {2'd1, 4'd15, 4'b0110, 36'h8_0402_0100},
    {2'd2, 4'd15, 4'b0000, 36'h0},
    {2'd0, 4'd0,  4'b0000, 36'h3_C3C3_C3C3},
    {2'd2, 4'd0,  4'b0000, 36'h0},
    {2'd1, 4'd0,  4'b1000, 36'hF_FFFF_FFFF},
    {2'd2, 4'd0,  4'b0000, 36'h0}
  };

  task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_sel();
    sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0;
  endtask

  task automatic set_read(input logic [AW-1:0] a);
    addr = a; wr_all_n = 1'b1; wr_lane_en_n = 1'b1; lane_wr_n = '1; din = '0;
  endtask

  function automatic logic [WW-1:0] merge(input logic [WW-1:0] old,
                                          input logic [WW-1:0] nw, input logic [NL-1:0] m);
    logic [WW-1:0] r = old;
    for (int l = 0; l < NL; l++) if (m[l]) r[l*LW +: LW] = nw[l*LW +: LW];
    return r;
  endfunction

  // write at one edge, then leave a selected dummy read applied
  task automatic wr_op(input bit whole, input logic [AW-1:0] a,
                       input logic [NL-1:0] m, input logic [WW-1:0] d);
    @(negedge clk);
    set_sel();
    addr = a; din = d; wr_all_n = !whole; wr_lane_en_n = 1'b0; lane_wr_n = ~m;
    model[a] = whole ? d : merge(model[a], d, m);
    @(negedge clk);
    set_read('0);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    set_sel(); set_read(a);
    @(negedge clk);
    set_read('0);
    @(negedge clk);
    check(dout_en === 1'b1, req, {35'd0, dout_en}, 36'd1);
    check(dout === model[a], req, dout, model[a]);
  endtask

  function automatic logic [WW-1:0] pat(input int i);
    return {4'(i), 8'(i * 3), 8'(i * 5), 8'(i * 7), 8'(i * 11)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sleep = 1'b0; oe_n = 1'b0;
    sel0_n = 1'b1; sel1 = 1'b0; sel2_n = 1'b1;
    set_read('0);
    repeat (3) @(negedge clk);
    check(dout_en === 1'b0, "R1 in reset", {35'd0, dout_en}, 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(dout_en === 1'b0, "R1 after reset", {35'd0, dout_en}, 36'd0);

    // preload every word with whole-word writes (R2)
    for (int i = 0; i < NW; i++) wr_op(1'b1, AW'(i), 4'b0000, pat(i));
    rd_chk(4'd9, "R2 preload");

    // table walk (R2 whole writes with partial strobes, R3/R10 lane writes, R4 reads)
    for (int v = 0; v < VN; v++) begin
      if (VEC[v][45:44] == 2'd2) rd_chk(VEC[v][43:40], "R4 table read");
      else wr_op(VEC[v][45:44] == 2'd0, VEC[v][43:40], VEC[v][39:36], VEC[v][35:0]);
    end

    // R10: lane 2 alone, check its slice and the check bit at bit 26
    wr_op(1'b0, 4'd11, 4'b0100, 36'h0_07F0_0000 | 36'h0_0400_0000);
    rd_chk(4'd11, "R10 lane2");
    check(dout[26] === 1'b1 && dout[25:18] === 8'hFC, "R10 lane2 slice",
          {27'd0, dout[26:18]}, {27'd0, 9'h1FC});

    // R5: write then read on the very next edge
    @(negedge clk);
    set_sel(); addr = 4'd6; din = 36'h9_1357_9BDF; wr_all_n = 1'b0;
    model[6] = 36'h9_1357_9BDF;
    @(negedge clk);
    set_read(4'd6);
    @(negedge clk);
    set_read('0);
    @(negedge clk);
    check(dout === model[6] && dout_en === 1'b1, "R5 write-then-read", dout, model[6]);

    // R3: lane strobes without the qualifier do nothing; qualifier with no lane reads
    @(negedge clk);
    set_sel(); addr = 4'd8; din = '1; wr_all_n = 1'b1; wr_lane_en_n = 1'b1; lane_wr_n = '0;
    @(negedge clk);
    addr = 4'd8; wr_lane_en_n = 1'b0; lane_wr_n = '1;
    @(negedge clk);
    set_read('0);
    @(negedge clk);
    check(dout === model[8] && dout_en === 1'b1, "R3 no-lane cycle reads", dout, model[8]);
    rd_chk(4'd8, "R3 unqualified strobes ignored");

    // R6: write with each select inactive leaves the word alone
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      set_sel();
      if (s == 0) sel0_n = 1'b1;
      if (s == 1) sel1 = 1'b0;
      if (s == 2) sel2_n = 1'b1;
      addr = 4'd4; din = 36'h5_5555_5555; wr_all_n = 1'b0;
      @(negedge clk);
      set_sel(); set_read('0);
      rd_chk(4'd4, "R6 deselected write");
    end

    // R7: deselect at the edge after a read kills the drive, for each select
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      set_sel(); set_read(4'd2);
      @(negedge clk);
      if (s == 0) sel0_n = 1'b1;
      if (s == 1) sel1 = 1'b0;
      if (s == 2) sel2_n = 1'b1;
      @(negedge clk);
      check(dout_en === 1'b0, "R7 deselect one edge", {35'd0, dout_en}, 36'd0);
    end
    // R7: select from idle takes two edges
    @(negedge clk);
    set_sel(); set_read(4'd9);
    @(negedge clk);
    set_read('0);
    check(dout_en === 1'b0, "R7 select first edge", {35'd0, dout_en}, 36'd0);
    @(negedge clk);
    check(dout_en === 1'b1 && dout === model[9], "R7 select second edge", dout, model[9]);

    // R8: asynchronous output enable
    oe_n = 1'b1; #1;
    check(dout_en === 1'b0, "R8 oe high", {35'd0, dout_en}, 36'd0);
    oe_n = 1'b0; #1;
    check(dout_en === 1'b1, "R8 oe low again", {35'd0, dout_en}, 36'd1);

    // R9: sleep drops drive at once and blocks a write
    rd_chk(4'd1, "R9 pre-sleep read");
    sleep = 1'b1;
    addr = 4'd5; din = 36'hE_EEEE_EEEE; wr_all_n = 1'b0; #1;
    check(dout_en === 1'b0, "R9 sleep async", {35'd0, dout_en}, 36'd0);
    @(negedge clk);
    check(dout_en === 1'b0, "R9 sleep after edge", {35'd0, dout_en}, 36'd0);
    set_read('0);
    @(negedge clk);
    sleep = 1'b0;
    rd_chk(4'd5, "R9 write in sleep blocked");

    finish_run();
  end

endmodule